// File: doc/BRIEF.md
# PC Card Attribute Configuration Registers

This block holds the attribute-memory configuration registers of a removable storage card. The host reaches it through a byte-wide attribute port, using a write strobe and a combinational read. Addresses below a fixed configuration base (0x200 by default) return bytes from a small computed card-information lookup. Any address past the end of that lookup returns zero.

Four registers sit above the base. They select the access mode and soft reset, report and accept status bits, expose the card-ready pin replacement, and provide a socket/copy slot that holds nothing. The block also merges the device interrupt request, two device-control bits and the soft-reset bit into the slot interrupt output. When a soft reset is requested, it sends a one-cycle reset pulse to the attached disk controller.

The attribute port has no back-pressure: every strobed write is accepted in the cycle it is presented, and `acc_rdata` always reflects `acc_addr`. Device-control writes arrive on their own plain strobe.

Top module: `pccard_attr_regs`

## Requirements
- R1: For an address below 0x200, the read data is `(a*29+7) mod 256` when the address `a` is below CIS_LEN (64 by default), and 0x00 otherwise.
- R2: A write to offset 0x00 stores the written byte ANDed with 0xCF, and a read at offset 0x00 returns the stored value. Bit 7 is the soft-reset request, bit 6 is the level-interrupt select and bits 5..0 are the mode field.
- R3: A write to offset 0x02 keeps the stored bits under mask 0x82 and loads the written bits under mask 0x74. On a read at offset 0x02, bit 1 equals the live device interrupt input, except that it reads 0 while device-control interrupt-off is set.
- R4: When a status write changes stored bit 2 (power-down), the card-ready flag is set. The flag stays set until a reset.
- R5: A read at offset 0x04 returns 0x0C ORed with 0x20 when card-ready is set. A write there leaves the card-ready flag unchanged.
- R6: Offset 0x06 and every other offset at or above the base that is not 0x00, 0x02 or 0x04 read 0x00. Writes to them change no register.
- R7: `slot_irq_o` is high only when the device interrupt input is low, both device-control bits are clear, and option bit 7 is clear. It follows changes within the same cycle, with no register delay.
- R8: A write that sets option bit 7 is visible for exactly one cycle. In that cycle `dev_rst_o` is high. At the next edge, option, status, card-ready and device control are all cleared, and any write presented in the pulse cycle is dropped.
- R9: A device-control write with `ctl_srst` set produces the same one-cycle pulse and clear as R8.
- R10: After the hardware reset, option and status read 0x00, pin replacement reads 0x0C, `dev_rst_o` is low and `slot_irq_o` is high while `dev_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Attribute access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Attribute byte address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Combinational read data for acc_addr |
| ctl_wr | input | 1 | Device-control write strobe |
| ctl_ien_off | input | 1 | Device-control interrupt-off bit |
| ctl_srst | input | 1 | Device-control soft-reset bit |
| dev_irq | input | 1 | Interrupt request from the disk controller |
| slot_irq_o | output | 1 | Slot interrupt, active high when firing |
| dev_rst_o | output | 1 | One-cycle reset pulse to the disk controller |

## Verification
A corrupted option or status register appears on the very next read of offset 0x00 or 0x02. A stuck device-control bit or soft-reset bit shows up in the same cycle as a `slot_irq_o` that refuses to rise while `dev_irq` is low. A lost card-ready flag is visible at the next pin-replacement read. A reset pending for the wrong number of cycles is caught in the cycle after the trigger, either by `dev_rst_o` or by register values that failed to clear.

// File: rtl/pccard_cfg_pkg.sv
package pccard_cfg_pkg;
  localparam logic [7:0] OFF_OPTION = 8'h00;
  localparam logic [7:0] OFF_STATUS = 8'h02;
  localparam logic [7:0] OFF_PINREP = 8'h04;
  localparam logic [7:0] OPT_MASK   = 8'hCF;
  localparam logic [7:0] STAT_KEEP  = 8'h82;
  localparam logic [7:0] STAT_LOAD  = 8'h74;
  localparam logic [7:0] PIN_CONST  = 8'h0C;
  localparam int         STAT_PWR_BIT = 2;
  localparam int         STAT_INT_BIT = 1;
  localparam int         OPT_SRST_BIT = 7;

  // Computed card-information byte for lookup index i.
  function automatic logic [7:0] cis_byte(input logic [7:0] i);
    return (i * 8'd29) + 8'd7;
  endfunction
endpackage

// File: rtl/pccard_cis_rom.sv
module pccard_cis_rom #(
  parameter int ADDR_W  = 12,
  parameter int CIS_LEN = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        data
);
  import pccard_cfg_pkg::*;
  localparam logic [ADDR_W-1:0] LEN_A = ADDR_W'(CIS_LEN);

  always_comb begin
    if (addr < LEN_A) data = cis_byte(addr[7:0]);
    else              data = 8'h00;
  end
endmodule

// File: rtl/pccard_cfg_state.sv
module pccard_cfg_state #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_off,
  input  logic [7:0]        wr_data,
  input  logic              ctl_wr,
  input  logic              ctl_ien_off,
  input  logic              ctl_srst,
  output logic [7:0]        opt_q,
  output logic [7:0]        stat_q,
  output logic              crdy_q,
  output logic [1:0]        ctrl_q,
  output logic              rst_pend
);
  import pccard_cfg_pkg::*;
  localparam logic [ADDR_W-1:0] O_OPT = ADDR_W'(OFF_OPTION);
  localparam logic [ADDR_W-1:0] O_STA = ADDR_W'(OFF_STATUS);

  logic wr_opt, wr_sta, trig;
  assign wr_opt = wr_en && (wr_off == O_OPT);
  assign wr_sta = wr_en && (wr_off == O_STA);
  assign trig   = (wr_opt && wr_data[OPT_SRST_BIT]) || (ctl_wr && ctl_srst);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q    <= '0;
      stat_q   <= '0;
      crdy_q   <= 1'b0;
      ctrl_q   <= '0;
      rst_pend <= 1'b0;
    end else if (rst_pend) begin
      opt_q    <= '0;
      stat_q   <= '0;
      crdy_q   <= 1'b0;
      ctrl_q   <= '0;
      rst_pend <= 1'b0;
    end else begin
      if (wr_opt) opt_q <= wr_data & OPT_MASK;
      if (wr_sta) begin
        stat_q <= (stat_q & STAT_KEEP) | (wr_data & STAT_LOAD);
        if (stat_q[STAT_PWR_BIT] != wr_data[STAT_PWR_BIT]) crdy_q <= 1'b1;
      end
      if (ctl_wr) ctrl_q <= {ctl_srst, ctl_ien_off};
      rst_pend <= trig;
    end
  end
endmodule

// File: rtl/pccard_irq_gate.sv
module pccard_irq_gate (
  input  logic       dev_irq,
  input  logic [1:0] ctrl_q,
  input  logic       opt_srst,
  output logic       slot_irq
);
  always_comb slot_irq = !dev_irq && (ctrl_q == 2'b00) && !opt_srst;
endmodule

// File: rtl/pccard_attr_regs.sv
module pccard_attr_regs #(
  parameter int ADDR_W   = 12,
  parameter int CFG_BASE = 'h200,
  parameter int CIS_LEN  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  input  logic              ctl_wr,
  input  logic              ctl_ien_off,
  input  logic              ctl_srst,
  input  logic              dev_irq,
  output logic              slot_irq_o,
  output logic              dev_rst_o
);
  import pccard_cfg_pkg::*;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] O_OPT  = ADDR_W'(OFF_OPTION);
  localparam logic [ADDR_W-1:0] O_STA  = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] O_PIN  = ADDR_W'(OFF_PINREP);

  logic              in_regs;
  logic [ADDR_W-1:0] off;
  logic [7:0]        rom_data, opt_q, stat_q;
  logic              crdy_q, rst_pend;
  logic [1:0]        ctrl_q;

  assign in_regs = (acc_addr >= BASE_A);
  assign off     = acc_addr - BASE_A;

  pccard_cis_rom #(.ADDR_W(ADDR_W), .CIS_LEN(CIS_LEN)) u_rom (
    .addr(acc_addr), .data(rom_data)
  );

  pccard_cfg_state #(.ADDR_W(ADDR_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc_valid && acc_write && in_regs),
    .wr_off(off), .wr_data(acc_wdata),
    .ctl_wr(ctl_wr), .ctl_ien_off(ctl_ien_off), .ctl_srst(ctl_srst),
    .opt_q(opt_q), .stat_q(stat_q), .crdy_q(crdy_q),
    .ctrl_q(ctrl_q), .rst_pend(rst_pend)
  );

  pccard_irq_gate u_irq (
    .dev_irq(dev_irq), .ctrl_q(ctrl_q),
    .opt_srst(opt_q[OPT_SRST_BIT]), .slot_irq(slot_irq_o)
  );

  assign dev_rst_o = rst_pend;

  always_comb begin
    acc_rdata = 8'h00;
    if (!in_regs) acc_rdata = rom_data;
    else if (off == O_OPT) acc_rdata = opt_q;
    else if (off == O_STA) begin
      acc_rdata = stat_q;
      acc_rdata[STAT_INT_BIT] = dev_irq && !ctrl_q[0];
    end
    else if (off == O_PIN) acc_rdata = PIN_CONST | {2'b00, crdy_q, 5'b00000};
  end
endmodule

// File: rtl/pccard_attr_regs_chk.sv
module pccard_attr_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dev_irq,
  input logic       slot_irq_o,
  input logic       dev_rst_o,
  input logic [7:0] opt_q,
  input logic [7:0] stat_q,
  input logic       crdy_q,
  input logic [1:0] ctrl_q
);
  // R7: a raised device request always silences the slot line
  p_irq_dev_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq |-> !slot_irq_o);
  // R7: while a soft reset is pending the slot line is gated off
  p_irq_softrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_o |-> !slot_irq_o);
  // R8: the reset pulse lasts a single cycle
  p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_o |=> !dev_rst_o);
  // R9: after the pulse every card register is cleared
  p_rst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_o |=> (opt_q == 8'h00 && stat_q == 8'h00 && !crdy_q && ctrl_q == 2'b00));
  // R4: card-ready is sticky until a reset
  p_crdy_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (crdy_q && !dev_rst_o) |=> crdy_q);
  // R2: bits 5:4 of the option register never hold a one
  p_opt_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_q & 8'h30) == 8'h00);
endmodule

bind pccard_attr_regs pccard_attr_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .slot_irq_o(slot_irq_o),
  .dev_rst_o(dev_rst_o), .opt_q(opt_q), .stat_q(stat_q),
  .crdy_q(crdy_q), .ctrl_q(ctrl_q)
);

// File: tb/tb_pccard_attr_regs.sv
module tb_pccard_attr_regs;
  localparam int AW = 12;
  localparam int BASE = 'h200;
  localparam int CLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, ctl_wr = 0, ctl_ien_off = 0, ctl_srst = 0, dev_irq = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0, acc_rdata;
  logic slot_irq_o, dev_rst_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_opt, m_stat;
  logic m_crdy, m_pend;
  logic [1:0] m_ctl;

  always #2 clk = ~clk;

  pccard_attr_regs dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ctl_wr(ctl_wr), .ctl_ien_off(ctl_ien_off), .ctl_srst(ctl_srst),
    .dev_irq(dev_irq), .slot_irq_o(slot_irq_o), .dev_rst_o(dev_rst_o)
  );

  function automatic logic [7:0] exp_rd(input int a);
    int o;
    if (a < BASE) return (a < CLEN) ? 8'((a * 29 + 7) % 256) : 8'h00;
    o = a - BASE;
    case (o)
      0: return m_opt;
      2: return (m_stat & 8'hFD) | ((dev_irq && !m_ctl[0]) ? 8'h02 : 8'h00);
      4: return 8'h0C | (m_crdy ? 8'h20 : 8'h00);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    if (a < BASE) return "R1";
    case (a - BASE)
      0: return "R2";
      2: return "R3";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_opt = 0; m_stat = 0; m_crdy = 0; m_pend = 0; m_ctl = 0;
  endtask

  // One cycle: drive at negedge, check before posedge, update model.
  task automatic cyc(input bit wr, input int a, input logic [7:0] d,
                     input bit cw, input bit cien, input bit csr, input bit irq);
    int o;
    @(negedge clk);
    acc_valid = wr; acc_write = wr; acc_addr = AW'(a); acc_wdata = d;
    ctl_wr = cw; ctl_ien_off = cien; ctl_srst = csr; dev_irq = irq;
    #1;
    check(tag_of(a), acc_rdata, exp_rd(a));
    check("R7", {7'd0, slot_irq_o}, {7'd0, (!irq && m_ctl == 2'b00 && !m_opt[7])});
    check("R8", {7'd0, dev_rst_o}, {7'd0, m_pend});
    if (m_pend) model_reset();
    else begin
      o = a - BASE;
      if (wr && a >= BASE) begin
        if (o == 0) begin m_opt = d & 8'hCF; if (d[7]) m_pend = 1; end
        if (o == 2) begin
          if (((m_stat ^ d) & 8'h04) != 0) m_crdy = 1;
          m_stat = (m_stat & 8'h82) | (d & 8'h74);
        end
      end
      if (cw) begin m_ctl = {csr, cien}; if (csr) m_pend = 1; end
    end
  endtask

  task automatic idle_rd(input int a, input bit irq);
    cyc(0, a, 8'h00, 0, 0, 0, irq);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    #9 rst_n = 1'b1;
    // R10: reset state
    idle_rd(BASE, 0);
    check("R10", acc_rdata, 8'h00);
    idle_rd(BASE + 2, 0);
    check("R10", acc_rdata, 8'h00);
    idle_rd(BASE + 4, 0);
    check("R10", acc_rdata, 8'h0C);
    check("R10", {7'd0, slot_irq_o}, 8'h01);
    // R1: lookup edges
    idle_rd(0, 0); idle_rd(CLEN - 1, 0); idle_rd(CLEN, 0); idle_rd(BASE - 1, 0);
    // R2: mask
    cyc(1, BASE, 8'h7F, 0, 0, 0, 0);
    idle_rd(BASE, 0);
    check("R2", acc_rdata, 8'h4F);
    // R6: socket/copy write ignored
    cyc(1, BASE + 6, 8'hFF, 0, 0, 0, 0);
    idle_rd(BASE + 6, 0);
    idle_rd(BASE, 0);
    check("R6", acc_rdata, 8'h4F);
    // R3/R4: power-down toggle sets card ready
    cyc(1, BASE + 2, 8'hFF, 0, 0, 0, 1);
    idle_rd(BASE + 2, 1);
    check("R3", acc_rdata, 8'h76);
    idle_rd(BASE + 4, 0);
    check("R4", acc_rdata, 8'h2C);
    // R5: pin write keeps card ready
    cyc(1, BASE + 4, 8'h00, 0, 0, 0, 0);
    idle_rd(BASE + 4, 0);
    check("R5", acc_rdata, 8'h2C);
    // R3: interrupt-off hides bit 1
    cyc(0, BASE + 2, 8'h00, 1, 1, 0, 1);
    idle_rd(BASE + 2, 1);
    check("R3", acc_rdata, 8'h74);
    // R7: slot line gated by ctrl
    check("R7", {7'd0, slot_irq_o}, 8'h00);
    cyc(0, BASE, 8'h00, 1, 0, 0, 0);
    // R9: soft reset from device control
    cyc(0, BASE, 8'h00, 1, 0, 1, 0);
    idle_rd(BASE + 4, 0);
    check("R9", {7'd0, dev_rst_o}, 8'h01);
    idle_rd(BASE + 4, 0);
    check("R9", acc_rdata, 8'h0C);
    // R8: soft reset through option bit 7, visible one cycle, write dropped
    cyc(1, BASE, 8'h81, 0, 0, 0, 0);
    cyc(1, BASE + 2, 8'h10, 0, 0, 0, 0);
    check("R8", acc_rdata, 8'h00);
    idle_rd(BASE, 0);
    check("R8", acc_rdata, 8'h00);
    idle_rd(BASE + 2, 0);
    check("R8", acc_rdata, 8'h00);
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int a;
      int sel = $urandom % 4;
      case (sel)
        0: a = $urandom % 128;
        1: a = BASE + ($urandom % 8);
        2: a = BASE + 2 * ($urandom % 3);
        default: a = $urandom % 4096;
      endcase
      cyc(($urandom % 2) == 1, a, 8'($urandom % 256),
          ($urandom % 10) == 0, ($urandom % 2) == 1, ($urandom % 4) == 0,
          ($urandom % 5) == 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule